// File: doc/BRIEF.md
# Trap-Entry Interrupt Dispatcher

This block performs the firmware-assisted part of interrupt entry for an operating system kernel. A trap-entry pulse brings in the select code of the channel that interrupted, a flag that marks the channel as a DMA channel, the prior state of the interrupt system and the current memory-map status. The block records this context in a vector area in memory. It then fetches the channel's word from an interrupt table in memory, classifies that word, and fetches the address of the matching handler. That address is returned as the new program counter.

All memory traffic uses a single synchronous word port. One access is made per cycle, and read data arrives in the cycle after the request. Three configuration words sit at fixed addresses: a pointer to the vector area, the table base and the table length. The block also emits a single clear-flag command toward the I/O system for the interrupting channel. The classified table word is driven on an output so that the handler receives it the way an accumulator would.

Top module: `irq_dispatch`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `io_stb` and `mem_req` are low, and `new_pc` and `entry_val` are zero.
- R2: On each entry, with V the word read from `VEC_PTR_ADDR`, the block writes `map_status` to V+0, the `intsys_was_off` flag (bit 0, upper bits zero) to V+1 and the select code (zero-extended) to V+2. It also writes the value 1 to `MPOFF_FLAG_ADDR`.
- R3: The table index is the select code minus 6. The table base is read from `TBL_BASE_ADDR` and the length from `TBL_LEN_ADDR`. When the index is no greater than the length (equal included), the table word is read from base plus index.
- R4: When the select code is below 6, or the index exceeds the length, the table word is taken as zero.
- R5: For a DMA-channel entry (`trap_dma` = 1), bit 15 of the table word is cleared before classification.
- R6: A classified word with bit 15 set (negative) selects the handler vector at V+6.
- R7: A nonzero classified word with bit 15 clear selects the handler vector at V+5.
- R8: A classified word of zero selects the handler vector at V+4.
- R9: For each entry, `done` pulses for exactly one cycle. In the same cycle `new_pc` holds the word read from the selected vector and `entry_val` holds the classified table word.
- R10: For each entry with a select code other than 5, `io_stb` pulses exactly once for one cycle, with `io_op` = 2'b01 (clear flag) and `io_sc` equal to the select code. For select code 5 no strobe is issued.
- R11: A `trap_start` pulse that arrives while `busy` is high is ignored. The running entry completes with its own inputs, and only one `done` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_start | input | 1 | One-cycle pulse that begins an interrupt entry |
| trap_sc | input | 6 | Select code of the interrupting channel |
| trap_dma | input | 1 | High when the interrupting channel is a DMA channel |
| intsys_was_off | input | 1 | Interrupt system was already off before entry |
| map_status | input | 16 | Memory-map status word to be recorded |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| io_stb | output | 1 | One-cycle I/O command strobe |
| io_op | output | 2 | I/O command code (2'b01 = clear flag) |
| io_sc | output | 6 | Select code the I/O command addresses |
| busy | output | 1 | An entry is in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Handler address fetched from the vector area |
| entry_val | output | 16 | Classified interrupt-table word |

## Verification
Assertions check several rules on every cycle. The clear-flag strobe never addresses select code 5 and never lasts two cycles. `done` is a single-cycle pulse. A DMA entry never finishes with bit 15 set, an out-of-range lookup always finishes with a zero word, and memory is never touched while idle. Only the bench scenarios can show the rest. These are that the right words land at the right vector-area addresses, that the handler address comes from the offset matching the word's sign and zero state, and that the bounds check puts the equal-length index inside the table. They also show that a second start pulse during an entry changes nothing.

// File: rtl/irq_dispatch_pkg.sv
// Package: shared state encoding and I/O command codes for the trap-entry
// dispatcher. Assumes a single sequencer owns the memory port.
package irq_dispatch_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VPTR,
        ST_TBASE,
        ST_TLEN,
        ST_WMAP,
        ST_WIOFF,
        ST_WSC,
        ST_WMPF,
        ST_TRD,
        ST_TCAP,
        ST_VRD,
        ST_DONE
    } disp_state_t;

    localparam logic [1:0] IO_CLR_FLAG = 2'b01;

endpackage

// File: rtl/irq_tbl_index.sv
// Module: forms the interrupt-table address for a select code and flags an
// out-of-range index. Purely combinational; assumes base and length words
// were already captured by the sequencer.
module irq_tbl_index #(
    parameter int DW       = 16,
    parameter int SC_W     = 6,
    parameter int FIRST_SC = 6
) (
    input  logic [SC_W-1:0] sc,
    input  logic [DW-1:0]   tbl_base,
    input  logic [DW-1:0]   tbl_len,
    output logic [DW-1:0]   tbl_addr,
    output logic            out_of_range
);
    localparam logic [DW-1:0] FIRST = DW'(FIRST_SC);

    logic [DW-1:0] sc_ext;
    logic [DW-1:0] idx;

    // Index is the select code relative to the first tabled channel
    always_comb begin
        sc_ext       = DW'(sc);
        idx          = sc_ext - FIRST;
        out_of_range = (sc_ext < FIRST) || (idx > tbl_len);
        tbl_addr     = tbl_base + idx;
    end
endmodule

// File: rtl/irq_classify.sv
// Module: strips the sign of a DMA-channel table word and picks the handler
// vector offset from the sign/zero state. Purely combinational.
module irq_classify #(
    parameter int DW       = 16,
    parameter int OFS_W    = 4,
    parameter int OFS_SKED = 6,
    parameter int OFS_DEV  = 5,
    parameter int OFS_ILL  = 4
) (
    input  logic [DW-1:0]    raw_entry,
    input  logic             is_dma,
    output logic [DW-1:0]    clean_entry,
    output logic [OFS_W-1:0] vec_ofs
);
    localparam logic [DW-1:0] SIGN_MASK = {1'b1, {(DW-1){1'b0}}};

    // Remove the sign for DMA channels, then route by sign and zero
    always_comb begin
        clean_entry = is_dma ? (raw_entry & ~SIGN_MASK) : raw_entry;
        if (clean_entry[DW-1])
            vec_ofs = OFS_W'(OFS_SKED);
        else if (clean_entry != '0)
            vec_ofs = OFS_W'(OFS_DEV);
        else
            vec_ofs = OFS_W'(OFS_ILL);
    end
endmodule

// File: rtl/irq_seq.sv
// Module: sequencer for one interrupt entry. Owns the memory port, all
// captured context, the I/O strobe and the result registers. Assumes read
// data arrives exactly one cycle after a read request.
module irq_seq
    import irq_dispatch_pkg::*;
#(
    parameter int              DW            = 16,
    parameter int              SC_W          = 6,
    parameter int              OFS_W         = 4,
    parameter int              MP_SC         = 5,
    parameter logic [DW-1:0]   VEC_PTR_ADDR  = 16'h0010,
    parameter logic [DW-1:0]   TBL_BASE_ADDR = 16'h0011,
    parameter logic [DW-1:0]   TBL_LEN_ADDR  = 16'h0012,
    parameter logic [DW-1:0]   MPOFF_ADDR    = 16'h0013
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SC_W-1:0]  sc_in,
    input  logic             dma_in,
    input  logic             ioff_in,
    input  logic [DW-1:0]    map_in,
    input  logic             oor,
    input  logic [DW-1:0]    tbl_addr,
    input  logic [DW-1:0]    clean_entry,
    input  logic [OFS_W-1:0] vec_ofs,
    output logic [SC_W-1:0]  sc_q,
    output logic             dma_q,
    output logic [DW-1:0]    tbase_q,
    output logic [DW-1:0]    tlen_q,
    output logic [DW-1:0]    entry_q,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             io_stb,
    output logic [1:0]       io_op,
    output logic [SC_W-1:0]  io_sc,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    new_pc,
    output logic [DW-1:0]    entry_val
);
    localparam logic [SC_W-1:0] MP_CODE = SC_W'(MP_SC);

    disp_state_t   state, nxt;
    logic [DW-1:0] vbase_q;
    logic [DW-1:0] map_q;
    logic          ioff_q;
    logic          oor_q;

    // Next-state selection for the entry walk
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_VPTR;
            ST_VPTR:  nxt = ST_TBASE;
            ST_TBASE: nxt = ST_TLEN;
            ST_TLEN:  nxt = ST_WMAP;
            ST_WMAP:  nxt = ST_WIOFF;
            ST_WIOFF: nxt = ST_WSC;
            ST_WSC:   nxt = ST_WMPF;
            ST_WMPF:  nxt = ST_TRD;
            ST_TRD:   nxt = oor ? ST_VRD : ST_TCAP;
            ST_TCAP:  nxt = ST_VRD;
            ST_VRD:   nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Memory request decode: one read or write per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_VPTR:  begin mem_req = 1'b1; mem_addr = VEC_PTR_ADDR; end
            ST_TBASE: begin mem_req = 1'b1; mem_addr = TBL_BASE_ADDR; end
            ST_TLEN:  begin mem_req = 1'b1; mem_addr = TBL_LEN_ADDR; end
            ST_WMAP:  begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = vbase_q; mem_wdata = map_q;
            end
            ST_WIOFF: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = vbase_q + DW'(1); mem_wdata = DW'(ioff_q);
            end
            ST_WSC:   begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = vbase_q + DW'(2); mem_wdata = DW'(sc_q);
            end
            ST_WMPF:  begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = MPOFF_ADDR; mem_wdata = DW'(1);
            end
            ST_TRD:   begin mem_req = !oor; mem_addr = tbl_addr; end
            ST_VRD:   begin mem_req = 1'b1; mem_addr = vbase_q + DW'(vec_ofs); end
            default:  ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Context capture: inputs on start, configuration words as they return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0; dma_q <= 1'b0; ioff_q <= 1'b0; map_q <= '0;
            vbase_q <= '0; tbase_q <= '0; tlen_q <= '0;
            entry_q <= '0; oor_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    sc_q <= sc_in; dma_q <= dma_in;
                    ioff_q <= ioff_in; map_q <= map_in;
                end
                ST_TBASE: vbase_q <= mem_rdata;
                ST_TLEN:  tbase_q <= mem_rdata;
                ST_WMAP:  tlen_q  <= mem_rdata;
                ST_TRD:   begin
                    oor_q <= oor;
                    if (oor) entry_q <= '0;
                end
                ST_TCAP:  entry_q <= mem_rdata;
                default:  ;
            endcase
        end
    end

    // Clear-flag strobe toward the I/O system, skipped for the protect channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_stb <= 1'b0; io_op <= 2'b00; io_sc <= '0;
        end else begin
            io_stb <= (state == ST_WMPF) && (sc_q != MP_CODE);
            if (state == ST_WMPF) begin
                io_op <= IO_CLR_FLAG;
                io_sc <= sc_q;
            end
        end
    end

    // Result registers and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; new_pc <= '0; entry_val <= '0;
        end else begin
            done <= (state == ST_DONE);
            if (state == ST_DONE) begin
                new_pc    <= mem_rdata;
                entry_val <= clean_entry;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    AST_IO_SKIPS_MP: assert property (@(posedge clk) disable iff (!rst_n)
        io_stb |-> (io_sc != MP_CODE)) else $error("clear flag sent to MP channel"); // R10
    AST_IO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        io_stb |=> !io_stb) else $error("io strobe held"); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held"); // R9
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && oor_q) |-> (entry_val == '0)) else $error("out-of-range word nonzero"); // R4
    AST_DMA_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dma_q) |-> !entry_val[DW-1]) else $error("dma word kept sign"); // R5
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req) else $error("memory used while idle"); // R1
endmodule

// File: rtl/irq_dispatch.sv
// Module: top of the trap-entry interrupt dispatcher. Ties the sequencer to
// the table-index and classification logic. Assumes a synchronous memory
// with one-cycle read latency on the word port.
module irq_dispatch #(
    parameter int            DW            = 16,
    parameter int            SC_W          = 6,
    parameter int            FIRST_SC      = 6,
    parameter int            MP_SC         = 5,
    parameter int            OFS_SKED      = 6,
    parameter int            OFS_DEV       = 5,
    parameter int            OFS_ILL       = 4,
    parameter logic [15:0]   VEC_PTR_ADDR  = 16'h0010,
    parameter logic [15:0]   TBL_BASE_ADDR = 16'h0011,
    parameter logic [15:0]   TBL_LEN_ADDR  = 16'h0012,
    parameter logic [15:0]   MPOFF_ADDR    = 16'h0013
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_start,
    input  logic [5:0]      trap_sc,
    input  logic            trap_dma,
    input  logic            intsys_was_off,
    input  logic [15:0]     map_status,
    output logic            mem_req,
    output logic            mem_we,
    output logic [15:0]     mem_addr,
    output logic [15:0]     mem_wdata,
    input  logic [15:0]     mem_rdata,
    output logic            io_stb,
    output logic [1:0]      io_op,
    output logic [5:0]      io_sc,
    output logic            busy,
    output logic            done,
    output logic [15:0]     new_pc,
    output logic [15:0]     entry_val
);
    localparam int OFS_MAX = (OFS_SKED > OFS_DEV) ?
                             ((OFS_SKED > OFS_ILL) ? OFS_SKED : OFS_ILL) :
                             ((OFS_DEV > OFS_ILL) ? OFS_DEV : OFS_ILL);
    localparam int OFS_W   = $clog2(OFS_MAX + 1);

    logic [SC_W-1:0]  sc_q;
    logic             dma_q;
    logic [DW-1:0]    tbase_q, tlen_q, entry_q;
    logic [DW-1:0]    tbl_addr, clean_entry;
    logic             oor;
    logic [OFS_W-1:0] vec_ofs;

    irq_tbl_index #(.DW(DW), .SC_W(SC_W), .FIRST_SC(FIRST_SC)) u_index (
        .sc(sc_q), .tbl_base(tbase_q), .tbl_len(tlen_q),
        .tbl_addr(tbl_addr), .out_of_range(oor)
    );

    irq_classify #(.DW(DW), .OFS_W(OFS_W), .OFS_SKED(OFS_SKED),
                   .OFS_DEV(OFS_DEV), .OFS_ILL(OFS_ILL)) u_class (
        .raw_entry(entry_q), .is_dma(dma_q),
        .clean_entry(clean_entry), .vec_ofs(vec_ofs)
    );

    irq_seq #(.DW(DW), .SC_W(SC_W), .OFS_W(OFS_W), .MP_SC(MP_SC),
              .VEC_PTR_ADDR(VEC_PTR_ADDR), .TBL_BASE_ADDR(TBL_BASE_ADDR),
              .TBL_LEN_ADDR(TBL_LEN_ADDR), .MPOFF_ADDR(MPOFF_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(trap_start),
        .sc_in(trap_sc), .dma_in(trap_dma), .ioff_in(intsys_was_off),
        .map_in(map_status), .oor(oor), .tbl_addr(tbl_addr),
        .clean_entry(clean_entry), .vec_ofs(vec_ofs),
        .sc_q(sc_q), .dma_q(dma_q), .tbase_q(tbase_q), .tlen_q(tlen_q),
        .entry_q(entry_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_stb(io_stb), .io_op(io_op), .io_sc(io_sc),
        .busy(busy), .done(done), .new_pc(new_pc), .entry_val(entry_val)
    );
endmodule

// File: tb/irq_dispatch_bench.sv
// Bench: vector table of entries walked by one loop, then directed reset
// and busy-restart checks. Memory is a bench-owned 256-word model.
module irq_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_start = 1'b0;
    logic [5:0]  trap_sc = '0;
    logic        trap_dma = 1'b0;
    logic        intsys_was_off = 1'b0;
    logic [15:0] map_status = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        io_stb, busy, done;
    logic [1:0]  io_op;
    logic [5:0]  io_sc;
    logic [15:0] new_pc, entry_val;

    int checks = 0;
    int fails  = 0;
    int io_cnt = 0;
    int done_cnt = 0;
    logic [5:0] io_last_sc = '0;
    logic [1:0] io_last_op = '0;
    logic [15:0] mem [256];

    localparam logic [7:0] VB = 8'h80;
    localparam logic [7:0] TB = 8'hA0;

    always #2 clk = ~clk;

    irq_dispatch u_irq_dispatch (
        .clk(clk), .rst_n(rst_n), .trap_start(trap_start), .trap_sc(trap_sc),
        .trap_dma(trap_dma), .intsys_was_off(intsys_was_off),
        .map_status(map_status), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_stb(io_stb), .io_op(io_op), .io_sc(io_sc), .busy(busy),
        .done(done), .new_pc(new_pc), .entry_val(entry_val)
    );

    // Memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    // Monitors for strobes and completion pulses
    always @(posedge clk) begin
        if (io_stb) begin
            io_cnt <= io_cnt + 1; io_last_sc <= io_sc; io_last_op <= io_op;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {sc, dma, table word, expected pc, expected entry}
    localparam logic [54:0] VECS [9] = '{
        {6'd10, 1'b0, 16'h0123, 16'h5555, 16'h0123},  // R7 positive
        {6'd12, 1'b0, 16'h8005, 16'h6666, 16'h8005},  // R6 negative
        {6'd8,  1'b0, 16'h0000, 16'h4444, 16'h0000},  // R8 zero
        {6'd6,  1'b1, 16'h8040, 16'h5555, 16'h0040},  // R5 dma strip, index 0
        {6'd7,  1'b1, 16'h8000, 16'h4444, 16'h0000},  // R5 strip to zero
        {6'd16, 1'b0, 16'hFFFF, 16'h6666, 16'hFFFF},  // R3 index equals length
        {6'd17, 1'b0, 16'h1234, 16'h4444, 16'h0000},  // R4 index beyond length
        {6'd5,  1'b0, 16'h7777, 16'h4444, 16'h0000},  // R4 below first, R10 no strobe
        {6'd4,  1'b1, 16'h8888, 16'h4444, 16'h0000}   // R4 below first
    };

    task automatic run_entry(input logic [5:0] sc, input logic dma,
                             input logic ioff, input logic [15:0] map);
        @(negedge clk);
        trap_sc = sc; trap_dma = dma; intsys_was_off = ioff; map_status = map;
        trap_start = 1'b1;
        @(negedge clk);
        trap_start = 1'b0;
        for (int w = 0; w < 60; w++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h10] = {8'h00, VB};
        mem[8'h11] = {8'h00, TB};
        mem[8'h12] = 16'd10;
        mem[VB + 8'd4] = 16'h4444;
        mem[VB + 8'd5] = 16'h5555;
        mem[VB + 8'd6] = 16'h6666;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {15'b0, busy}, 16'h0);
        chk("R1 done", {15'b0, done}, 16'h0);
        chk("R1 io_stb", {15'b0, io_stb}, 16'h0);
        chk("R1 mem_req", {15'b0, mem_req}, 16'h0);
        chk("R1 new_pc", new_pc, 16'h0);
        chk("R1 entry_val", entry_val, 16'h0);
        rst_n = 1'b1;

        for (int v = 0; v < 9; v++) begin
            logic [5:0]  sc;
            logic        dma;
            logic [15:0] tw, epc, eent, mapw;
            logic        ioff;
            {sc, dma, tw, epc, eent} = VECS[v];
            mapw = 16'hA000 + 16'(v);
            ioff = v[0];
            mem[8'(TB + 8'(sc) - 8'd6)] = tw;
            mem[VB] = '0; mem[VB + 8'd1] = 16'hDEAD; mem[VB + 8'd2] = '0;
            mem[8'h13] = '0;
            io_cnt = 0; done_cnt = 0;
            run_entry(sc, dma, ioff, mapw);
            chk("R9 done seen", {15'b0, done}, 16'h1);
            chk("R6/R7/R8 new_pc", new_pc, epc);
            chk("R9/R5 entry_val", entry_val, eent);
            @(negedge clk);
            chk("R9 done width", 16'(done_cnt), 16'd1);
            chk("R2 map word", mem[VB], mapw);
            chk("R2 ioff word", mem[VB + 8'd1], {15'b0, ioff});
            chk("R2 sc word", mem[VB + 8'd2], {10'b0, sc});
            chk("R2 mp flag", mem[8'h13], 16'h1);
            if (sc == 6'd5) begin
                chk("R10 no strobe", 16'(io_cnt), 16'd0);
            end else begin
                chk("R10 strobe count", 16'(io_cnt), 16'd1);
                chk("R10 strobe sc", {10'b0, io_last_sc}, {10'b0, sc});
                chk("R10 strobe op", {14'b0, io_last_op}, 16'h1);
            end
        end

        // R11 restart while busy is ignored
        mem[8'(TB + 8'd3)] = 16'h0055;   // sc 9, positive
        mem[8'(TB + 8'd4)] = 16'h8001;   // sc 10, negative
        io_cnt = 0; done_cnt = 0;
        @(negedge clk);
        trap_sc = 6'd9; trap_dma = 1'b0; map_status = 16'h1111; trap_start = 1'b1;
        @(negedge clk);
        trap_start = 1'b0;
        repeat (2) @(negedge clk);
        trap_sc = 6'd10; map_status = 16'h2222; trap_start = 1'b1;
        @(negedge clk);
        trap_start = 1'b0;
        repeat (40) @(negedge clk);
        chk("R11 single done", 16'(done_cnt), 16'd1);
        chk("R11 new_pc", new_pc, 16'h5555);
        chk("R11 entry_val", entry_val, 16'h0055);
        chk("R11 sc word", mem[VB + 8'd2], 16'd9);
        chk("R11 map word", mem[VB], 16'h1111);
        chk("R11 strobe sc", {10'b0, io_last_sc}, 16'd9);

        // R1 reset mid-entry returns to idle
        run_entry(6'd10, 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        trap_start = 1'b1;
        @(negedge clk);
        trap_start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", {15'b0, busy}, 16'h0);
        chk("R1 new_pc after reset", new_pc, 16'h0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule